// File: doc/BRIEF.md
# Multi-mode PWM with buffered duty registers

This peripheral produces two pulse outputs from one shared 16-bit counter. An 8-bit control register picks the output personality, the counter's clock source and a prescaler. The personalities are a single variable-resolution PWM, twin and dual 8-bit PWM, twin 16-bit PWM, and two first-order sigma-delta DAC modes with non-return-to-zero and return-to-zero pulse shapes. Two 16-bit data channels are loaded a byte at a time through a byte-wide write port.

Duty values never reach the outputs mid-cycle. Each channel has a pending value and an active value. In the 16-bit personalities the low byte waits in a hidden staging byte and reaches the pending value only when the high byte is written. The active value copies the pending value at the end of each output cycle, and also when the control register is written. The counter advances on a divided tick. The four `clk_en` strobes are the candidate sources, and the bit picked by the source field feeds the prescaler. One of those strobes is expected to come from an external pin, already synchronised.

Top module: `pwm_multi`

## Requirements
- R1: During and after reset the control value is 0x00 and both outputs are low.
- R2: With mode field (control bits 6:4) 000 or 111 both outputs stay low.
- R3: In mode 001, channel 0 holds the period P and channel 1 the high time H. With the counter value c taking 0..P and then wrapping to 0, `pwm_out1` is high when c < H and `pwm_out0` is low.
- R4: Control bits 1:0 select `clk_en[bits]` as the count source. Control bits 3:2 divide that source by 1, 4, 16 or 64 (codes 00..11), so the counter steps once every D source strobes.
- R5: A write to address 0 (control) resets the counter, the prescaler and the DAC state, and loads each channel's pending value into its active value.
- R6: In modes 001, 011, 100 and 110, a write to a channel's low byte (address 1 for channel 0, address 3 for channel 1) changes only a staging byte. A write to its high byte (address 2 or 4) sets the pending value to {high, staged low}. In all other modes a byte write goes directly into that byte of the pending value.
- R7: Pending values become active only at the end of the running output cycle. A data write in the same clock as that end is applied at the following cycle end.
- R8: In mode 010, the low 8 bits of the counter run 0..255. `pwm_out0` is high while they are below channel 0 bits 7:0, and `pwm_out1` is high while they are below channel 1 bits 7:0.
- R9: In mode 101 both 8-bit duties come from channel 0. Bits 7:0 drive `pwm_out0` and bits 15:8 drive `pwm_out1`, and channel 1 has no effect.
- R10: In mode 011 the counter runs 0..65535. Each output is high while the counter is below its channel's 16-bit value.
- R11: In mode 100, each channel adds its value into a 16-bit accumulator on every tick. The output equals the carry of the latest addition.
- R12: In mode 110 additions happen on every second tick. The output shows the carry for the tick after the addition and is low for the tick that follows.
- R13: When control bit 7 is set, `pwm_out0` is low in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1/2 channel 0 low/high, 3/4 channel 1 low/high |
| wr_data | input | 8 | Write byte |
| clk_en | input | 4 | Candidate count strobes; one is an external pin strobe |
| pwm_out0 | output | 1 | Output 0 |
| pwm_out1 | output | 1 | Output 1 |

## Verification
Two events can fall in the same clock: a high-byte data write and the end of an output cycle. The bench places the high-byte write exactly on the edge where the mode-001 counter wraps from P to 0. It expects the old high time to stay in force for one more full period and the new one to appear only at the next wrap. The 8-bit and 16-bit boundary cases are checked the same way, with each expected waveform computed from the sample index, the period and the divider.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int SRC_N     = 4;
    localparam int SRC_SEL_W = $clog2(SRC_N);
    localparam int PRE_W     = 6;

    localparam logic [2:0] ADDR_CTRL = 3'd0;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_VAR    = 3'd1,
        MODE_TWIN8  = 3'd2,
        MODE_TWIN16 = 3'd3,
        MODE_NRZ    = 3'd4,
        MODE_DUAL8  = 3'd5,
        MODE_RZ     = 3'd6,
        MODE_RSVD   = 3'd7
    } pwm_mode_e;

    typedef struct packed {
        logic            out0_off;
        pwm_mode_e       mode;
        logic [1:0]      div;
        logic [SRC_SEL_W-1:0] src;
    } pwm_ctrl_t;

    function automatic logic mode_wide(pwm_mode_e m);
        return (m == MODE_VAR) || (m == MODE_TWIN16) ||
               (m == MODE_NRZ) || (m == MODE_RZ);
    endfunction

    function automatic logic mode_runs(pwm_mode_e m);
        return (m != MODE_OFF) && (m != MODE_RSVD);
    endfunction

    function automatic logic [PRE_W-1:0] div_limit(logic [1:0] d);
        logic [PRE_W:0] t;
        t = (PRE_W+1)'(1) << {d, 1'b0};
        return t[PRE_W-1:0] - 1'b1;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 run,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic [SRC_N-1:0]     src_en,
    input  logic [1:0]           div,
    output logic                 tick
);
    logic [PRE_W-1:0] pre_q;
    logic             src;

    assign src  = src_en[src_sel];
    assign tick = run && src && (pre_q == div_limit(div));

    always_ff @(posedge clk) begin
        if (rst || clear)
            pre_q <= '0;
        else if (run && src)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/pwm_chan_reg.sv
module pwm_chan_reg #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wide,
    input  logic [BYTE_W-1:0] data,
    input  logic              load,
    output logic [VAL_W-1:0]  act
);
    logic [BYTE_W-1:0] stage_q;
    logic [VAL_W-1:0]  pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            pend_q  <= '0;
            act     <= '0;
        end else begin
            if (wr_lo) begin
                if (wide) stage_q <= data;
                else      pend_q[BYTE_W-1:0] <= data;
            end
            if (wr_hi) begin
                if (wide) pend_q <= {data, stage_q};
                else      pend_q[VAL_W-1:BYTE_W] <= data;
            end
            if (load)
                act <= pend_q;
        end
    end
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  pwm_mode_e        mode,
    input  logic [CNT_W-1:0] act0,
    input  logic [CNT_W-1:0] act1,
    output logic             raw0,
    output logic             raw1,
    output logic             boundary,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0]  acc0_q, acc1_q;
    logic              cy0_q, cy1_q, phase_q;
    logic [BYTE_W-1:0] cnt_lo;
    logic [CNT_W:0]    sum0, sum1;

    assign cnt_lo = cnt[BYTE_W-1:0];
    assign sum0   = {1'b0, acc0_q} + {1'b0, act0};
    assign sum1   = {1'b0, acc1_q} + {1'b0, act1};

    always_comb begin
        boundary = 1'b0;
        if (tick) begin
            unique case (mode)
                MODE_VAR:              boundary = (cnt >= act0);
                MODE_TWIN8, MODE_DUAL8: boundary = (cnt_lo == '1);
                MODE_TWIN16:           boundary = (cnt == '1);
                MODE_NRZ:              boundary = 1'b1;
                MODE_RZ:               boundary = !phase_q;
                default:               boundary = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt     <= '0;
            acc0_q  <= '0;
            acc1_q  <= '0;
            cy0_q   <= 1'b0;
            cy1_q   <= 1'b0;
            phase_q <= 1'b0;
        end else if (tick) begin
            unique case (mode)
                MODE_VAR:    cnt <= (cnt >= act0) ? '0 : cnt + 1'b1;
                MODE_TWIN8, MODE_DUAL8:
                             cnt <= {{BYTE_W{1'b0}}, cnt_lo + 1'b1};
                MODE_TWIN16: cnt <= cnt + 1'b1;
                MODE_NRZ: begin
                    {cy0_q, acc0_q} <= sum0;
                    {cy1_q, acc1_q} <= sum1;
                end
                MODE_RZ: begin
                    phase_q <= !phase_q;
                    if (!phase_q) begin
                        {cy0_q, acc0_q} <= sum0;
                        {cy1_q, acc1_q} <= sum1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        raw0 = 1'b0;
        raw1 = 1'b0;
        unique case (mode)
            MODE_VAR:    raw1 = (cnt < act1);
            MODE_TWIN8: begin
                raw0 = (cnt_lo < act0[BYTE_W-1:0]);
                raw1 = (cnt_lo < act1[BYTE_W-1:0]);
            end
            MODE_DUAL8: begin
                raw0 = (cnt_lo < act0[BYTE_W-1:0]);
                raw1 = (cnt_lo < act0[CNT_W-1:BYTE_W]);
            end
            MODE_TWIN16: begin
                raw0 = (cnt < act0);
                raw1 = (cnt < act1);
            end
            MODE_NRZ: begin
                raw0 = cy0_q;
                raw1 = cy1_q;
            end
            MODE_RZ: begin
                raw0 = cy0_q & phase_q;
                raw1 = cy1_q & phase_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SRC_N-1:0] clk_en,
    output logic             pwm_out0,
    output logic             pwm_out1
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int NCH   = 2;

    pwm_ctrl_t        ctrl_q;
    logic             ctrl_wr, tick, bnd, chan_load, raw0, raw1;
    logic [CNT_W-1:0] act_q [NCH];
    logic [CNT_W-1:0] act0_w, act1_w, cnt_w;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign chan_load = ctrl_wr || bnd;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= pwm_ctrl_t'(wr_data[7:0]);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam logic [2:0] LO_ADDR = 3'(1 + 2 * i);
        localparam logic [2:0] HI_ADDR = 3'(2 + 2 * i);
        pwm_chan_reg #(.BYTE_W(BYTE_W)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (wr_en && (wr_addr == LO_ADDR)),
            .wr_hi (wr_en && (wr_addr == HI_ADDR)),
            .wide  (mode_wide(ctrl_q.mode)),
            .data  (wr_data),
            .load  (chan_load),
            .act   (act_q[i])
        );
    end

    assign act0_w = act_q[0];
    assign act1_w = act_q[1];

    pwm_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctrl_wr),
        .run     (mode_runs(ctrl_q.mode)),
        .src_sel (ctrl_q.src),
        .src_en  (clk_en),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    pwm_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctrl_wr),
        .tick     (tick),
        .mode     (ctrl_q.mode),
        .act0     (act0_w),
        .act1     (act1_w),
        .raw0     (raw0),
        .raw1     (raw1),
        .boundary (bnd),
        .cnt      (cnt_w)
    );

    assign pwm_out0 = raw0 && !ctrl_q.out0_off;
    assign pwm_out1 = raw1;
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic         pwm_out0,
    input logic         pwm_out1,
    input logic [7:0]   ctrl_bits,
    input logic         load,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act0,
    input logic [W-1:0] act1
);
    logic [2:0] md;
    assign md = ctrl_bits[6:4];

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        (md == 3'd0 || md == 3'd7) |-> (!pwm_out0 && !pwm_out1));

    assert_var_out0_low_R3: assert property (@(posedge clk) disable iff (rst)
        (md == 3'd1) |-> !pwm_out0);

    assert_ctrl_clears_cnt_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> (cnt == '0));

    assert_hold_between_bounds_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act0) && $stable(act1)));

    assert_out0_off_R13: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[7] |-> !pwm_out0);
endmodule

bind pwm_multi pwm_multi_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .pwm_out0  (pwm_out0),
    .pwm_out1  (pwm_out1),
    .ctrl_bits (ctrl_q),
    .load      (chan_load),
    .cnt       (cnt_w),
    .act0      (act0_w),
    .act1      (act1_w)
);

// File: tb/sim_pwm_multi.sv
module sim_pwm_multi;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] clk_en = 4'b0001;
    logic       o0, o1;

    int checks = 0;
    int fails  = 0;
    int k      = 0;

    always #10 clk = ~clk;

    pwm_multi u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_en(clk_en),
        .pwm_out0(o0), .pwm_out1(o1)
    );

    task automatic cmp(string req, logic e0, logic e1);
        checks++;
        if (o0 !== e0 || o1 !== e1) begin
            fails++;
            $display("FAIL %s k=%0d actual=%b%b expected=%b%b", req, k, o0, o1, e0, e1);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        k++;
    endtask

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic wr16(int ch, logic [15:0] v);
        wr(3'(1 + 2 * ch), v[7:0]);
        wr(3'(2 + 2 * ch), v[15:8]);
    endtask

    task automatic sync(logic [7:0] c);
        wr(3'd0, c);
        k = 0;
    endtask

    function automatic logic ev(int kk, int d, int p, int h);
        return ((kk / d) % (p + 1)) < h;
    endfunction

    function automatic logic carry(int m, int v);
        longint a, b;
        if (m == 0) return 1'b0;
        a = (longint'(m) * v) >> 16;
        b = (longint'(m - 1) * v) >> 16;
        return a != b;
    endfunction

    task automatic run_var(string req, int dv, int p, int h, int n);
        logic [7:0] c;
        c = {1'b0, 3'd1, 2'(dv), 2'b00};
        wr(3'd0, c);
        wr16(0, 16'(p));
        wr16(1, 16'(h));
        sync(c);
        for (int i = 0; i < n; i++) begin
            cmp(req, 1'b0, ev(k, 1 << (2 * dv), p, h));
            if (i < n - 1) step();
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            cmp("R1 after reset", 1'b0, 1'b0);
        end

        // R3 period/high-time sweep, including H=0 and H>P
        run_var("R3 p9h3", 0, 9, 3, 30);
        run_var("R3 p0h1", 0, 0, 1, 8);
        run_var("R3 p0h0", 0, 0, 0, 8);
        run_var("R3 p5h9", 0, 5, 9, 12);
        run_var("R3 p20h13", 0, 20, 13, 50);

        // R6 staging and R7 boundary in mode 1
        run_var("R3 p9h3", 0, 9, 3, 16);
        wr(3'd3, 8'd7);
        cmp("R6 low byte staged", 1'b0, ev(k, 1, 9, 3));
        wr(3'd4, 8'd0);
        while (k < 25) begin
            cmp("R7 apply at wrap", 1'b0, ev(k, 1, 9, (k >= 20) ? 7 : 3));
            step();
        end
        cmp("R7 apply at wrap", 1'b0, ev(k, 1, 9, 7));
        wr(3'd3, 8'd2);
        while (k < 29) begin
            cmp("R6 low byte staged", 1'b0, ev(k, 1, 9, 7));
            step();
        end
        cmp("R6 low byte staged", 1'b0, ev(k, 1, 9, 7));
        wr(3'd4, 8'd0);
        while (k < 50) begin
            cmp("R7 write on wrap edge", 1'b0, ev(k, 1, 9, (k >= 40) ? 2 : 7));
            step();
        end
        wr(3'd3, 8'h55);
        sync(8'h10);
        for (int i = 0; i < 20; i++) begin
            cmp("R5 R6 sync keeps pending", 1'b0, ev(k, 1, 9, 2));
            step();
        end

        // R4 dividers
        for (int dv = 1; dv < 4; dv++)
            run_var("R4 divider", dv, 3, 2, 8 * (1 << (2 * dv)));

        // R4 source select
        sync(8'h11);
        for (int i = 0; i < 40; i++) begin
            cmp("R4 unselected source frozen", 1'b0, 1'b1);
            step();
        end
        clk_en = 4'b0010;
        sync(8'h11);
        for (int i = 0; i < 16; i++) begin
            cmp("R4 selected source runs", 1'b0, ev(k, 1, 3, 2));
            step();
        end
        clk_en = 4'b0001;

        // R2 idle modes
        sync(8'h00);
        for (int i = 0; i < 20; i++) begin
            cmp("R2 mode 0", 1'b0, 1'b0);
            step();
        end
        sync(8'h70);
        for (int i = 0; i < 20; i++) begin
            cmp("R2 mode 7", 1'b0, 1'b0);
            step();
        end

        // R8 twin 8-bit with boundary
        wr(3'd0, 8'h20);
        wr(3'd1, 8'h40);
        wr(3'd3, 8'hC0);
        sync(8'h20);
        for (int i = 0; i < 300; i++) begin
            cmp("R8 twin8", (k % 256) < 64, (k % 256) < 192);
            if (i < 299) step();
        end
        wr(3'd1, 8'h10);
        while (k < 600) begin
            cmp("R7 R8 8-bit boundary", (k % 256) < ((k >= 512) ? 16 : 64), (k % 256) < 192);
            step();
        end

        // R13 out0 disable
        sync(8'hA0);
        for (int i = 0; i < 256; i++) begin
            cmp("R13 out0 off", 1'b0, (k % 256) < 192);
            step();
        end

        // R9 dual 8-bit, channel 1 ignored
        wr(3'd0, 8'h50);
        wr(3'd1, 8'h10);
        wr(3'd2, 8'hF0);
        wr(3'd3, 8'h80);
        wr(3'd4, 8'h00);
        sync(8'h50);
        for (int i = 0; i < 512; i++) begin
            cmp("R9 dual8", (k % 256) < 16, (k % 256) < 240);
            step();
        end

        // R10 twin 16-bit with boundary at 65536
        wr(3'd0, 8'h30);
        wr16(0, 16'h0100);
        wr16(1, 16'h0003);
        sync(8'h30);
        for (int i = 0; i < 300; i++) begin
            cmp("R10 twin16", k < 256, k < 3);
            if (i < 299) step();
        end
        wr16(1, 16'h0005);
        while (k < 65546) begin
            if (k >= 65536)
                cmp("R10 R7 16-bit boundary", (k - 65536) < 256, (k - 65536) < 5);
            else
                cmp("R10 R7 16-bit boundary", k < 256, k < 3);
            step();
        end

        // R11 NRZ sigma-delta
        wr(3'd0, 8'h40);
        wr16(0, 16'h4000);
        wr16(1, 16'hC000);
        sync(8'h40);
        for (int i = 0; i < 64; i++) begin
            cmp("R11 nrz", carry(k, 32'h4000), carry(k, 32'hC000));
            step();
        end

        // R12 RZ sigma-delta
        wr(3'd0, 8'h60);
        wr16(0, 16'h8000);
        wr16(1, 16'h3000);
        sync(8'h60);
        for (int i = 0; i < 64; i++) begin
            if (k % 2 == 1)
                cmp("R12 rz", carry((k + 1) / 2, 32'h8000), carry((k + 1) / 2, 32'h3000));
            else
                cmp("R12 rz", 1'b0, 1'b0);
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule